// File: doc/BRIEF.md
# Error Output Channel Mask Register

This block stores a 32-bit enable mask that decides which error channels may act on an external error output. Mask bit n stands for channel 32+n, so the upper half of the word (bits 31:16) covers channels 63:48 and the lower half (bits 15:0) covers channels 47:32. Software reaches the one stored mask through two word offsets on a simple memory-mapped bus. Writing ones at the set offset turns channels on. Writing ones at the clear offset turns them off. Both offsets read back the same mask.

Reads are open to both user and privileged accesses. A write changes the mask only when the access is flagged privileged. A user-mode write finishes on the bus as normal and leaves the mask as it was. The block also presents the mask directly. It ANDs each channel's failure flag with its mask bit, and it ORs those gated flags into one request for the downstream error-pin controller.

Top module: `err_pin_mask_regs`

## Requirements
- R1: After reset the mask is all zeros, bus_rdata is zero and pin_req is low.
- R2: A privileged write at byte offset 0x540 (the set offset) sets every mask bit whose write-data bit is 1.
- R3: A privileged write at byte offset 0x544 (the clear offset) clears every mask bit whose write-data bit is 1.
- R4: A write-data bit of 0 at either offset leaves that mask bit unchanged.
- R5: A write with bus_priv low leaves the whole mask unchanged at either offset.
- R6: A read (bus_rd high) at either offset returns the current mask on bus_rdata one cycle after the strobe, whether bus_priv is high or low. bus_rdata holds its value while bus_rd is low.
- R7: A read at any other offset returns zero. A write at any other offset leaves the mask unchanged.
- R8: gated[n] equals chan_fail[n] AND mask bit n, where index n is channel 32+n.
- R9: pin_req is high exactly when any bit of gated is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte offset in the register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chan_fail | input | 32 | Failure flags, bit n is channel 32+n |
| mask_q | output | 32 | Stored enable mask |
| gated | output | 32 | Failure flags ANDed with the mask |
| pin_req | output | 1 | OR of all gated flags |

## Verification
The embedded assertions check the following on every cycle: that set and clear writes move only the bits whose write-data bit is 1, that unprivileged and idle cycles keep the mask stable, and that a read of either offset returns the mask from the cycle before. The reset values and the all-zero return for other offsets are shown only by the bench's scenarios. The same holds for the gating of particular failure patterns, including channels at both halves of the word. The bench also shows that reads from user mode agree with privileged reads.

// File: rtl/err_pin_mask_regs.sv
module err_pin_mask_regs #(
  parameter int NCH = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SET_OFS = 12'h540,
  parameter logic [ADDR_W-1:0] CLR_OFS = 12'h544
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCH-1:0]    bus_wdata,
  output logic [NCH-1:0]    bus_rdata,
  input  logic [NCH-1:0]    chan_fail,
  output logic [NCH-1:0]    mask_q,
  output logic [NCH-1:0]    gated,
  output logic              pin_req
);

  logic hit_set, hit_clr, wr_ok;
  logic [NCH-1:0] mask;

  assign hit_set = (bus_addr == SET_OFS);
  assign hit_clr = (bus_addr == CLR_OFS);
  assign wr_ok   = bus_wr && bus_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask <= '0;
    else if (wr_ok && hit_set)
      mask <= mask | bus_wdata;
    else if (wr_ok && hit_clr)
      mask <= mask & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= (hit_set || hit_clr) ? mask : '0;
  end

  assign mask_q  = mask;
  assign gated   = chan_fail & mask;
  assign pin_req = |gated;

  p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hit_set) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hit_clr) |=> ((mask_q & $past(bus_wdata)) == '0));

  p_zero_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> ((mask_q & ~$past(bus_wdata)) == ($past(mask_q) & ~$past(bus_wdata))));

  p_user_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_priv)) |=> $stable(mask_q));

  p_read_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (hit_set || hit_clr)) |=> (bus_rdata == $past(mask_q)));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata));

endmodule

// File: tb/err_pin_mask_regs_tb.sv
module err_pin_mask_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] chan_fail = '0;
  logic [31:0] mask_q, gated;
  logic        pin_req;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;
  bit done = 0;

  localparam logic [11:0] SET_A = 12'h540;
  localparam logic [11:0] CLR_A = 12'h544;

  always #2 clk = ~clk;

  err_pin_mask_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .chan_fail(chan_fail), .mask_q(mask_q),
    .gated(gated), .pin_req(pin_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk);
    bus_wr = 1'b0; bus_priv = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic p, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_priv = p;
    @(negedge clk);
    bus_rd = 1'b0; bus_priv = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    check("R1 mask", mask_q, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 pin_req", {31'h0, pin_req}, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(SET_A, 32'h8001_0001, 1'b1); model |= 32'h8001_0001;
    check("R2 set", mask_q, model);
    wr(SET_A, 32'h0000_00F0, 1'b1); model |= 32'h0000_00F0;
    check("R4 set zeros keep", mask_q, model);
    rd(SET_A, 1'b1, d); check("R6 read set alias", d, model);
    rd(CLR_A, 1'b1, d); check("R6 read clear alias", d, model);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(CLR_A, 32'h0000_0011, 1'b1); model &= ~32'h0000_0011;
    check("R3 clear", mask_q, model);
    check("R4 clear zeros keep", mask_q, 32'h8001_00E0);
    wr(CLR_A, 32'h0, 1'b1);
    check("R4 clear all-zero data", mask_q, model);
    rd(CLR_A, 1'b0, d); check("R6 user read", d, model);
  endtask

  task automatic t_user();
    wr(SET_A, 32'hFFFF_FFFF, 1'b0);
    check("R5 user set ignored", mask_q, model);
    wr(CLR_A, 32'hFFFF_FFFF, 1'b0);
    check("R5 user clear ignored", mask_q, model);
  endtask

  task automatic t_other();
    logic [31:0] d;
    rd(12'h548, 1'b1, d); check("R7 other read zero", d, 32'h0);
    wr(12'h53C, 32'hFFFF_FFFF, 1'b1);
    check("R7 other write ignored", mask_q, model);
    @(negedge clk);
    check("R6 rdata holds", bus_rdata, 32'h0);
  endtask

  task automatic t_gate();
    chan_fail = 32'h7FFE_FF0F; #1;
    check("R8 gated none", gated, 32'h0);
    check("R9 pin_req low", {31'h0, pin_req}, 32'h0);
    chan_fail = 32'h8000_0000; #1;
    check("R8 gated ch63", gated, 32'h8000_0000);
    check("R9 pin_req high", {31'h0, pin_req}, 32'h1);
    chan_fail = 32'hFFFF_FFFF; #1;
    check("R8 gated all", gated, model);
    chan_fail = '0;
  endtask

  initial begin
    #1; t_reset();
    #10 rst_n = 1'b1;
    t_reset();
    t_set();
    t_clear();
    t_user();
    t_other();
    t_gate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog got=%h exp=%h", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule